// File: doc/BRIEF.md
# Shared-Comparator Multichannel Sync-Word Detector

This block monitors a group of serial lines, all sampled from one free-running system clock, and flags every occurrence of a fixed synchronisation word on any of them. The lines carry no framing, so the word may start at any bit position. Each line is sampled at twice its bit rate. Even-numbered samples form the phase-0 stream and odd-numbered samples form the phase-1 stream. Each stream keeps its own sliding history of the last PAT_W bits. Whichever stream lines up with the transmitter's bit centres produces the match, and the phase index of the report tells the consumer which stream that was.

Only one equality comparator exists. After each sample strobe, a slot sweep walks the comparator across every channel of the phase that was just sampled, one channel per system clock. Every history value is therefore checked once, after it is updated and before it can change again. A match produces a one-cycle report that carries the channel and the phase. A two-flop synchroniser sits in front of each raw input. The sync word is an elaboration-time parameter that is shared by all channels. SAMPLE_DIV must be at least NUM_CH.

Top module: `syncWordDetector`

## Requirements
- R1: A sample strobe occurs once every SAMPLE_DIV cycles. Cycle 0 is the cycle that begins at the last rising edge with rst high, and sample k (counting from 0) is taken by the edge that ends cycle (k+1)*SAMPLE_DIV-1. Even k feeds phase 0 and odd k feeds phase 1, and every report carries the phase of the stream that matched (0 = phase 0, 1 = phase 1).
- R2: Each stream shifts its newest bit into the least significant end of its history. A match means that the earliest of the last PAT_W bits of the stream equals PATTERN's most significant bit, and so on down to the newest bit, which equals PATTERN's LSB. A match is found at any bit position, with no framing.
- R3: A match raises detValid for exactly one cycle, and detCh gives the channel index (the serialIn bit number). Whenever detValid is low, detCh and detPhase are zero.
- R4: For a sample taken by the edge that ends cycle t, the result for channel n is on the outputs during cycle t+2+n. Each (channel, phase) history is compared exactly once per sample of its phase. A serialIn bit must be stable from at least two edges before the sampling edge, because it passes two synchroniser flops.
- R5: The two phase streams are independent. A match that exists only in one stream is reported only with that stream's phase.
- R6: When both phases of a channel match within one bit period, two separate reports appear, one for each phase, in different cycles.
- R7: After reset, a stream's comparison is masked until PAT_W samples have entered that stream. With an all-zero PATTERN and all-zero inputs, the first report is channel 0 phase 0 in cycle 63*SAMPLE_DIV+1 (for PAT_W = 32).
- R8: While rst (synchronous, active high) is applied, all histories clear and detValid, detCh and detPhase read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling and the slot sweep run on it |
| rst | input | 1 | Synchronous active-high reset |
| serialIn | input | NUM_CH | Raw serial lines, one bit per channel |
| detValid | output | 1 | One-cycle pulse for each matching (channel, phase) slot |
| detCh | output | CH_W | Channel index of the current report, zero when idle |
| detPhase | output | 1 | Phase stream of the current report, zero when idle |

## Verification
Each result is due at a fixed cycle. A bit driven during cycle k*SAMPLE_DIV is taken at the end of cycle (k+1)*SAMPLE_DIV-1, and channel n's verdict for it shows on the outputs two plus n cycles after that sampling cycle. The bench drives every input in the first cycle of a sample period, well clear of the two synchroniser edges. Its reference model works out, at each sampling cycle, the exact future cycle of each expected report. It then compares the outputs of both instances at the falling edge of every cycle, and a missing report, an extra report or an early report fails at once. The masking check on the all-zero-pattern instance is pinned to the single cycle 63*SAMPLE_DIV+1 after a mid-run reset.

// File: rtl/syncWordPkg.sv
package syncWordPkg;

  // Strobes passed from the slot controller to the datapath each cycle.
  typedef struct packed {
    logic sampleEn;     // take a sample into the banks this cycle
    logic samplePhase;  // which phase bank receives it
    logic cmpEn;        // the shared comparator is in use this cycle
    logic cmpPhase;     // phase bank the comparator reads
  } slotStrobe_t;

endpackage

// File: rtl/syncWordSync.sv
module syncWordSync #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] rawIn,
  output logic [NUM_CH-1:0] syncOut
);

  logic [NUM_CH-1:0] stage1;

  // Two flops per line; the second one is the only one the banks read.
  always_ff @(posedge clk) begin
    if (rst) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= rawIn;
      syncOut <= stage1;
    end
  end

endmodule

// File: rtl/syncWordCompare.sv
module syncWordCompare #(
  parameter int             PAT_W   = 32,
  parameter logic [PAT_W-1:0] PATTERN = '0
) (
  input  logic [PAT_W-1:0] candidate,
  input  logic             armed,
  output logic             hit
);

  // The single equality comparator shared by every slot.
  always_comb hit = armed && (candidate == PATTERN);

endmodule

// File: rtl/syncWordCtrl.sv
module syncWordCtrl
  import syncWordPkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int SAMPLE_DIV = 16,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int DIV_W     = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1
) (
  input  logic            clk,
  input  logic            rst,
  output slotStrobe_t     stb,
  output logic [CH_W-1:0] slotCh
);

  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SAMPLE_DIV - 1);

  logic [DIV_W-1:0] divCnt;
  logic             phaseNext;   // phase of the upcoming sample
  logic             lastPhase;   // phase of the most recent sample
  logic             sampledOnce; // the banks have taken at least one sample

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt      <= '0;
      phaseNext   <= 1'b0;
      lastPhase   <= 1'b0;
      sampledOnce <= 1'b0;
    end else if (divCnt == DIV_LAST) begin
      divCnt      <= '0;
      phaseNext   <= ~phaseNext;
      lastPhase   <= phaseNext;
      sampledOnce <= 1'b1;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // The sweep occupies the first NUM_CH cycles of each sample period, so every
  // bank entry is compared after its update and before the next strobe.
  always_comb begin
    stb.sampleEn    = (divCnt == DIV_LAST);
    stb.samplePhase = phaseNext;
    stb.cmpEn       = sampledOnce && (int'(divCnt) < NUM_CH);
    stb.cmpPhase    = lastPhase;
    slotCh          = CH_W'(divCnt);
  end

endmodule

// File: rtl/syncWordDatapath.sv
module syncWordDatapath
  import syncWordPkg::*;
#(
  parameter int               NUM_CH  = 16,
  parameter int               PAT_W   = 32,
  parameter logic [PAT_W-1:0] PATTERN = '0,
  localparam int              CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int              FILL_W  = $clog2(PAT_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] serialIn,
  input  slotStrobe_t       stb,
  input  logic [CH_W-1:0]   slotCh,
  output logic              detValid,
  output logic [CH_W-1:0]   detCh,
  output logic              detPhase
);

  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(PAT_W);

  logic [NUM_CH-1:0] syncBits;
  logic [PAT_W-1:0]  bankSel  [2];
  logic              bankFull [2];
  logic [PAT_W-1:0]  candidate;
  logic              armed;
  logic              hit;

  syncWordSync #(.NUM_CH(NUM_CH)) i_sync (
    .clk     (clk),
    .rst     (rst),
    .rawIn   (serialIn),
    .syncOut (syncBits)
  );

  // One history bank per phase; all streams of a phase fill together, so a
  // single fill counter per bank masks the whole bank.
  for (genvar ph = 0; ph < 2; ph++) begin : g_bank
    logic [PAT_W-1:0]  bankHist [NUM_CH];
    logic [FILL_W-1:0] fillCnt;
    logic              bankLoad;

    assign bankLoad = stb.sampleEn && (stb.samplePhase == ph[0]);

    always_ff @(posedge clk) begin
      if (rst) begin
        fillCnt <= '0;
        for (int ch = 0; ch < NUM_CH; ch++) bankHist[ch] <= '0;
      end else if (bankLoad) begin
        if (fillCnt != FILL_FULL) fillCnt <= fillCnt + 1'b1;
        for (int ch = 0; ch < NUM_CH; ch++)
          bankHist[ch] <= {bankHist[ch][PAT_W-2:0], syncBits[ch]};
      end
    end

    assign bankSel[ph]  = bankHist[slotCh];
    assign bankFull[ph] = (fillCnt == FILL_FULL);
  end

  always_comb begin
    candidate = bankSel[stb.cmpPhase];
    armed     = stb.cmpEn && bankFull[stb.cmpPhase];
  end

  syncWordCompare #(.PAT_W(PAT_W), .PATTERN(PATTERN)) i_cmp (
    .candidate (candidate),
    .armed     (armed),
    .hit       (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      detValid <= 1'b0;
      detCh    <= '0;
      detPhase <= 1'b0;
    end else begin
      detValid <= hit;
      detCh    <= hit ? slotCh : '0;
      detPhase <= hit && stb.cmpPhase;
    end
  end

endmodule

// File: rtl/syncWordDetector.sv
module syncWordDetector
  import syncWordPkg::*;
#(
  parameter int               NUM_CH     = 16,
  parameter int               PAT_W      = 32,
  parameter logic [PAT_W-1:0] PATTERN    = 32'h1ACF_FC1D,
  parameter int               SAMPLE_DIV = 16,
  localparam int              CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] serialIn,
  output logic              detValid,
  output logic [CH_W-1:0]   detCh,
  output logic              detPhase
);

  slotStrobe_t     stb;
  logic [CH_W-1:0] slotCh;

  syncWordCtrl #(.NUM_CH(NUM_CH), .SAMPLE_DIV(SAMPLE_DIV)) i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .stb    (stb),
    .slotCh (slotCh)
  );

  syncWordDatapath #(.NUM_CH(NUM_CH), .PAT_W(PAT_W), .PATTERN(PATTERN)) i_dp (
    .clk      (clk),
    .rst      (rst),
    .serialIn (serialIn),
    .stb      (stb),
    .slotCh   (slotCh),
    .detValid (detValid),
    .detCh    (detCh),
    .detPhase (detPhase)
  );

endmodule

// File: rtl/syncWordChecker.sv
module syncWordChecker
  import syncWordPkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CH_W   = 4
) (
  input logic            clk,
  input logic            rst,
  input slotStrobe_t     stb,
  input logic [CH_W-1:0] slotCh,
  input logic            detValid,
  input logic [CH_W-1:0] detCh,
  input logic            detPhase
);

  // R1: a strobe never repeats on the next cycle
  p_single_strobe_r1: assert property (@(posedge clk) disable iff (rst)
    stb.sampleEn |=> !stb.sampleEn);

  // R1: consecutive samples go to alternating phases
  p_phase_alternate_r1: assert property (@(posedge clk) disable iff (rst)
    stb.sampleEn |=> (stb.samplePhase != $past(stb.samplePhase)));

  // R4: a sweep of the just-sampled bank starts the cycle after the strobe
  p_sweep_start_r4: assert property (@(posedge clk) disable iff (rst)
    stb.sampleEn |=> (stb.cmpEn && slotCh == '0 && stb.cmpPhase == $past(stb.samplePhase)));

  // R4: back-to-back reports inside one sweep step through channels in order
  p_report_order_r4: assert property (@(posedge clk) disable iff (rst)
    (detValid && $past(detValid) && $past(detCh) != CH_W'(NUM_CH - 1)) |->
      (detCh == CH_W'($past(detCh) + 1) && detPhase == $past(detPhase)));

  // R3: indices are zero while no report is shown
  p_idle_index_r3: assert property (@(posedge clk) disable iff (rst)
    !detValid |-> (detCh == '0 && !detPhase));

  // R3: a report names the slot that the comparator served one cycle earlier
  p_report_slot_r3: assert property (@(posedge clk) disable iff (rst)
    detValid |-> ($past(stb.cmpEn) && detCh == $past(slotCh) && detPhase == $past(stb.cmpPhase)));

  // R8: no report in the first cycle after reset
  p_reset_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !detValid);

endmodule

bind syncWordDetector syncWordChecker #(.NUM_CH(NUM_CH), .CH_W(CH_W)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .stb      (stb),
  .slotCh   (slotCh),
  .detValid (detValid),
  .detCh    (detCh),
  .detPhase (detPhase)
);

// File: tb/test_syncWordDetector.sv
module test_syncWordDetector;

  localparam int NCH = 16;
  localparam int PW  = 32;
  localparam int DIV = 16;
  localparam int CW  = 4;
  localparam logic [PW-1:0] PAT = 32'h1ACF_FC1D;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] serA = '0;
  logic [NCH-1:0] serZ = '0;
  logic detA, phA, detZ, phZ;
  logic [CW-1:0] chA, chZ;

  always #10ns clk = ~clk;

  syncWordDetector #(.NUM_CH(NCH), .PAT_W(PW), .PATTERN(PAT), .SAMPLE_DIV(DIV)) i_syncWordDetector (
    .clk(clk), .rst(rst), .serialIn(serA), .detValid(detA), .detCh(chA), .detPhase(phA));

  syncWordDetector #(.NUM_CH(NCH), .PAT_W(PW), .PATTERN('0), .SAMPLE_DIV(DIV)) i_zeroPat (
    .clk(clk), .rst(rst), .serialIn(serZ), .detValid(detZ), .detCh(chZ), .detPhase(phZ));

  typedef struct packed { int cyc; int ch; int ph; } ev_t;
  ev_t qA[$];
  ev_t qZ[$];

  logic [PW-1:0] mHistA [2][NCH];
  logic [PW-1:0] mHistZ [2][NCH];
  int            mFill  [2];
  logic          curBit [NCH];
  logic          held   [NCH];
  int unsigned   nState;
  int            obs    [NCH][2];
  int            cyc, total, bad, zFirst;

  task automatic tally(input bit ok, input string tag, input string what,
                       input int got, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s cyc=%0d got=%0d exp=%0d", tag, what, cyc, got, expv);
    end
  endtask

  function automatic int unsigned xs(input int unsigned x);
    int unsigned y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  // Compare both instances against the expected event queues.
  task automatic checkOutputs();
    ev_t e;
    int  eDet, eCh, ePh;
    string tag;
    eDet = 0; eCh = 0; ePh = 0;
    if (qA.size() > 0 && qA[0].cyc == cyc) begin
      e = qA.pop_front(); eDet = 1; eCh = e.ch; ePh = e.ph;
    end
    if (int'(detA) != eDet) tag = "R4";
    else if (int'(chA) != eCh) tag = "R3";
    else tag = "R5";
    tally(int'(detA) == eDet && int'(chA) == eCh && int'(phA) == ePh, tag,
          "main det*100+ch*2+ph", int'(detA)*100 + int'(chA)*2 + int'(phA),
          eDet*100 + eCh*2 + ePh);
    if (detA) obs[chA][phA]++;

    eDet = 0; eCh = 0; ePh = 0;
    if (qZ.size() > 0 && qZ[0].cyc == cyc) begin
      e = qZ.pop_front(); eDet = 1; eCh = e.ch; ePh = e.ph;
    end
    tally(int'(detZ) == eDet && int'(chZ) == eCh && int'(phZ) == ePh, "R7",
          "zero det*100+ch*2+ph", int'(detZ)*100 + int'(chZ)*2 + int'(phZ),
          eDet*100 + eCh*2 + ePh);
    if (detZ && zFirst < 0) zFirst = cyc;
  endtask

  // Reference model of one sample taken at the end of cycle t.
  task automatic modelSample(input int t);
    int k, ph;
    ev_t e;
    k  = t / DIV;
    ph = k % 2;
    if (mFill[ph] < PW) mFill[ph]++;
    for (int ch = 0; ch < NCH; ch++) begin
      mHistA[ph][ch] = {mHistA[ph][ch][PW-2:0], curBit[ch]};
      mHistZ[ph][ch] = {mHistZ[ph][ch][PW-2:0], 1'b0};
      if (mFill[ph] == PW) begin
        e.cyc = t + 2 + ch; e.ch = ch; e.ph = ph;
        if (mHistA[ph][ch] == PAT) qA.push_back(e);
        if (mHistZ[ph][ch] == '0) qZ.push_back(e);
      end
    end
  endtask

  // Stimulus for sample k: channel mode = ch % 4
  //   0: pattern in both phases, 1: pattern on phase 0 and its inverse on phase 1,
  //   2: idle zeros, 3: fresh noise every sample.
  task automatic driveSample(input int k);
    int j, off;
    logic base, b;
    j = k / 2;
    for (int ch = 0; ch < NCH; ch++) begin
      nState = xs(nState);
      if (k % 2 == 0) held[ch] = nState[3];
      off  = (j % (60 + ch)) - (20 + ch % 3);
      base = (off >= 0 && off < PW) ? PAT[PW-1-off] : held[ch];
      case (ch % 4)
        0:       b = base;
        1:       b = (k % 2 == 0) ? base : ~base;
        2:       b = 1'b0;
        default: b = nState[7];
      endcase
      curBit[ch] = b;
      serA[ch]   = b;
    end
  endtask

  task automatic stepCycle();
    checkOutputs();
    if (cyc % DIV == DIV - 1) modelSample(cyc);
    if (cyc % DIV == 0) driveSample(cyc / DIV);
  endtask

  task automatic applyReset();
    rst  = 1'b1;
    serA = '0;
    repeat (3) @(negedge clk);
    tally(detA == 1'b0 && chA == '0 && phA == 1'b0, "R8", "main outputs in reset",
          int'(detA) + int'(chA) + int'(phA), 0);
    tally(detZ == 1'b0 && chZ == '0 && phZ == 1'b0, "R8", "zero outputs in reset",
          int'(detZ) + int'(chZ) + int'(phZ), 0);
    qA.delete();
    qZ.delete();
    mFill[0] = 0;
    mFill[1] = 0;
    for (int p = 0; p < 2; p++)
      for (int ch = 0; ch < NCH; ch++) begin
        mHistA[p][ch] = '0;
        mHistZ[p][ch] = '0;
      end
    for (int ch = 0; ch < NCH; ch++) curBit[ch] = 1'b0;
    zFirst = -1;
    rst = 1'b0;
    cyc = 0;
    stepCycle();
  endtask

  task automatic runCycles(input int n);
    repeat (n) begin
      @(negedge clk);
      cyc++;
      stepCycle();
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    total = 0; bad = 0; nState = 32'h2545_F491;
    for (int ch = 0; ch < NCH; ch++) begin
      obs[ch][0] = 0; obs[ch][1] = 0; held[ch] = 1'b0;
    end

    applyReset();
    runCycles(DIV * 300);

    // R6: channel 0 carries the word on both phases
    tally(obs[0][0] > 0 && obs[0][1] > 0, "R6", "ch0 phase0/phase1 reports",
          obs[0][0] * 1000 + obs[0][1], 1);
    // R5: channel 1 carries the word only on phase 0
    tally(obs[1][0] > 0, "R5", "ch1 phase0 reports", obs[1][0], 1);
    tally(obs[1][1] == 0, "R5", "ch1 phase1 reports", obs[1][1], 0);
    // R2: word found at an unaligned offset on another channel, idle line silent
    tally(obs[4][0] > 0, "R2", "ch4 phase0 reports", obs[4][0], 1);
    tally(obs[2][0] + obs[2][1] == 0, "R2", "idle ch2 reports", obs[2][0] + obs[2][1], 0);
    // R7: the all-zero pattern fired once its banks filled
    tally(zFirst == 63 * DIV + 1, "R7", "first zero-pattern report cycle", zFirst, 63 * DIV + 1);

    // Mid-run reset while the zero-pattern instance reports every slot.
    applyReset();
    runCycles(DIV * 80);
    tally(zFirst == 63 * DIV + 1, "R7", "first report after second reset", zFirst, 63 * DIV + 1);

    summary();
    $finish;
  end

  initial begin
    #2ms;
    total++;
    bad++;
    $display("FAIL watchdog expired cyc=%0d got=running exp=done", cyc);
    summary();
    $finish;
  end

endmodule